// File: doc/BRIEF.md
# Single-Frame Receive Buffer with Byte-Wise Host Readout

This block holds one incoming Ethernet frame and lets a host fetch it one byte per read access. Frames arrive on a byte-stream port with start, end and valid markers. A frame is taken only while the device is idle and the previous frame's bytes no longer fill the store. No address filtering is applied. Once a frame is taken, the block raises its busy flag. When the last byte has been stored, it sends a one-cycle receive-done event to the interrupt logic.

The host reads through a data strobe. Each strobe returns the byte at the read pointer, one cycle later, and lowers the remaining-byte count by one. Once the count is zero, a strobe returns zero and changes nothing. The control block lowers busy with a clear pulse. A device reset discards the held frame: it zeroes the count and the read pointer, sets busy and leaves the storage array untouched. A frame longer than the store is cut off at the store's size.

Top module: `rxb_top`

## Requirements
- R1: After reset, busy is 1, rx_count is 0, in_ready is 0, rx_done is 0 and rd_data is 0.
- R2: in_ready is 1 exactly when busy is 0 and rx_count is below 1514. A beat with in_valid and in_sof while in_ready is 0 is refused: rx_count does not change and no rx_done follows.
- R3: A beat with in_valid and in_sof while in_ready is 1 starts a frame. From the next cycle, busy is 1 and rx_count equals the number of bytes stored so far. The start beat carries byte 0.
- R4: rx_done is high for exactly one cycle, the cycle after the clock edge that takes the in_eof beat of an accepted frame. A frame may be a single beat with in_sof and in_eof both set.
- R5: A frame longer than 1514 bytes keeps its first 1514 bytes. rx_count stays at 1514 and later bytes are dropped.
- R6: A rd_strobe while rx_count is nonzero and no frame is being taken returns the next unread byte on rd_data in the following cycle, in arrival order, and lowers rx_count by 1. rd_data holds until the next strobe.
- R7: A rd_strobe while rx_count is 0 gives rd_data 0 in the next cycle and leaves rx_count at 0.
- R8: Accepting a new frame resets the read pointer, so the next read returns the new frame's first byte, even if the previous frame was only partly read.
- R9: A dev_rst pulse sets rx_count to 0 and busy to 1, drops any frame in progress without an rx_done, and gives rd_data 0.
- R10: A rd_strobe in a cycle where a frame is being taken or accepted is ignored: rd_data reads 0 afterwards and rx_count is not lowered.
- R11: busy falls only on a busy_clr pulse, one cycle after it, and otherwise stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_rst | input | 1 | Synchronous device reset pulse from the control block |
| busy_clr | input | 1 | Pulse from the control block that lowers busy |
| in_valid | input | 1 | Network beat valid |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Network byte |
| in_ready | output | 1 | A frame start would be accepted this cycle |
| rd_strobe | input | 1 | Host read of the data register |
| rd_data | output | 8 | Byte returned by the last read |
| rx_count | output | 11 | Bytes not yet read |
| busy | output | 1 | Device busy flag |
| rx_done | output | 1 | One-cycle receive-done event |

## Verification
Every registered result is due in the cycle after the edge that samples its cause. busy, rx_count and rd_data follow a start beat, a stored byte or a read strobe by one edge. rx_done follows the end beat by one edge. in_ready follows busy and rx_count combinationally, with no added delay. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each comparison sees exactly one rising edge's worth of change. Its behavioural model steps once per rising edge, and its directed checks read results one edge after each stimulus.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic {
    ING_IDLE = 1'b0,
    ING_FILL = 1'b1
  } ing_state_e;

  // Next value of the remaining-byte count for one clock edge.
  function automatic int unsigned cnt_step(int unsigned cur, logic load_first,
                                           logic store_one, logic take_one);
    if (load_first) return 1;
    if (store_one)  return cur + 1;
    if (take_one)   return cur - 1;
    return cur;
  endfunction

  // True while the store can still take another byte.
  function automatic logic has_room(int unsigned cur, int unsigned cap);
    return cur < cap;
  endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DEPTH  = 1514,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/rxb_ingress.sv
module rxb_ingress
  import rxb_pkg::*;
#(
  parameter int MAX_BYTES = 1514,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1),
  parameter int ADDR_W    = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              busy,
  input  logic [CNT_W-1:0]  count,
  output logic              can_start,
  output logic              accept,
  output logic              store_en,
  output logic [ADDR_W-1:0] store_addr,
  output logic              frame_end,
  output logic              writing
);

  ing_state_e state_q, state_d;
  logic       room;

  assign room       = has_room(32'(count), 32'(MAX_BYTES));
  assign writing    = (state_q == ING_FILL);
  assign can_start  = !busy && !writing && room;
  assign accept     = in_valid && in_sof && can_start;
  assign store_en   = accept || (writing && in_valid && room);
  assign store_addr = accept ? '0 : count[ADDR_W-1:0];
  assign frame_end  = in_valid && in_eof && (accept || writing);

  always_comb begin
    state_d = state_q;
    if (accept && !in_eof)                 state_d = ING_FILL;
    else if (writing && in_valid && in_eof) state_d = ING_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= ING_IDLE;
    else if (dev_rst) state_q <= ING_IDLE;
    else              state_q <= state_d;
  end

  // A full store must not take further bytes of the same frame.
  AST_NO_STORE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (writing && in_valid && count == CNT_W'(MAX_BYTES)) |-> !store_en) else
    $error("byte stored past capacity"); // R5

  // Nothing is written while no frame is in progress and none starts.
  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!writing && !accept) |-> !store_en) else
    $error("store outside a frame"); // R2

endmodule

// File: rtl/rxb_egress.sv
module rxb_egress #(
  parameter int MAX_BYTES = 1514,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1),
  parameter int ADDR_W    = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst,
  input  logic              rd_strobe,
  input  logic [CNT_W-1:0]  count,
  input  logic              writing,
  input  logic              accept,
  output logic              rd_ok,
  output logic [ADDR_W-1:0] rd_ptr
);

  assign rd_ok = rd_strobe && (count != '0) && !writing && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_ptr <= '0;
    else if (dev_rst) rd_ptr <= '0;
    else if (accept)  rd_ptr <= '0;
    else if (rd_ok)   rd_ptr <= rd_ptr + ADDR_W'(1);
  end

  // Accepting a frame rewinds the pointer.
  AST_PTR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dev_rst) |=> (rd_ptr == '0)) else
    $error("read pointer not rewound"); // R8

  // A read of an empty buffer leaves the pointer where it was.
  AST_EMPTY_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && count == '0 && !accept && !dev_rst) |=> $stable(rd_ptr)) else
    $error("pointer moved on empty read"); // R7

endmodule

// File: rtl/rxb_top.sv
module rxb_top
  import rxb_pkg::*;
#(
  parameter int MAX_BYTES = 1514,
  parameter int DATA_W    = 8,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int ADDR_W   = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst,
  input  logic              busy_clr,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rx_count,
  output logic              busy,
  output logic              rx_done
);

  // Named internal events
  logic              ev_accept;
  logic              ev_store;
  logic              ev_frame_end;
  logic              ev_read;
  logic              writing;
  logic              can_start;
  logic [ADDR_W-1:0] store_addr;
  logic [ADDR_W-1:0] rd_ptr;
  logic [DATA_W-1:0] store_q;
  logic              rd_hit_q;
  logic [CNT_W-1:0]  count_q;
  logic              busy_q;
  logic              done_q;

  rxb_ingress #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ingress (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_rst    (dev_rst),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .busy       (busy_q),
    .count      (count_q),
    .can_start  (can_start),
    .accept     (ev_accept),
    .store_en   (ev_store),
    .store_addr (store_addr),
    .frame_end  (ev_frame_end),
    .writing    (writing)
  );

  rxb_egress #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_egress (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_rst   (dev_rst),
    .rd_strobe (rd_strobe),
    .count     (count_q),
    .writing   (writing),
    .accept    (ev_accept),
    .rd_ok     (ev_read),
    .rd_ptr    (rd_ptr)
  );

  rxb_store #(.DEPTH(MAX_BYTES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (ev_store),
    .wr_addr (store_addr),
    .wr_data (in_data),
    .rd_en   (ev_read),
    .rd_addr (rd_ptr),
    .rd_q    (store_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (dev_rst) count_q <= '0;
    else              count_q <= CNT_W'(cnt_step(32'(count_q), ev_accept, ev_store, ev_read));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_q <= 1'b1;
    else if (dev_rst)   busy_q <= 1'b1;
    else if (ev_accept) busy_q <= 1'b1;
    else if (busy_clr)  busy_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (dev_rst) done_q <= 1'b0;
    else              done_q <= ev_frame_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_hit_q <= 1'b0;
    else if (dev_rst)   rd_hit_q <= 1'b0;
    else if (rd_strobe) rd_hit_q <= ev_read;
  end

  assign in_ready = can_start;
  assign rd_data  = rd_hit_q ? store_q : '0;
  assign rx_count = count_q;
  assign busy     = busy_q;
  assign rx_done  = done_q;

  AST_READY_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready) else $error("ready while busy"); // R2

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy) else $error("busy not set on accept"); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done) else $error("rx_done longer than one cycle"); // R4

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(MAX_BYTES)) else $error("count above capacity"); // R5

  AST_READ_LOWERS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_read && !dev_rst) |=> (rx_count == $past(rx_count) - CNT_W'(1))) else
    $error("read did not lower count"); // R6

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rx_count == '0) |=> (rd_data == '0)) else
    $error("empty read returned data"); // R7

  AST_DEVRST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> (busy && rx_count == '0 && !rx_done)) else
    $error("device reset state wrong"); // R9

  AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !busy_clr) |=> busy) else $error("busy fell without clear"); // R11

  AST_WRITE_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && (writing || ev_accept)) |=> (rd_data == '0)) else
    $error("read served during frame intake"); // R10

endmodule

// File: tb/rxb_top_tb_top.sv
`timescale 1ns/1ps
module rxb_top_tb_top;

  localparam int MAXB = 1514;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_rst = 1'b0;
  logic        busy_clr = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        rd_strobe = 1'b0;
  logic        in_ready;
  logic [7:0]  rd_data;
  logic [10:0] rx_count;
  logic        busy;
  logic        rx_done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  rxb_top dut_i (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .busy_clr(busy_clr),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .in_ready(in_ready), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .rx_count(rx_count), .busy(busy), .rx_done(rx_done)
  );

  // Behavioural reference model, stepped once per rising edge.
  int   m_cnt = 0;
  int   m_rptr = 0;
  bit   m_busy = 1;
  bit   m_fill = 0;
  bit   m_done = 0;
  int   m_rd = 0;
  int   m_buf [MAXB];

  always @(posedge clk) begin
    bit acc;
    bit fin;
    if (!rst_n || dev_rst) begin
      m_cnt = 0; m_rptr = 0; m_busy = 1; m_fill = 0; m_done = 0; m_rd = 0;
    end else begin
      acc = in_valid && in_sof && !m_busy && !m_fill && (m_cnt < MAXB);
      fin = 0;
      if (rd_strobe) begin
        if (m_cnt > 0 && !m_fill && !acc) begin
          m_rd = m_buf[m_rptr]; m_rptr++; m_cnt--;
        end else m_rd = 0;
      end
      if (acc) begin
        m_buf[0] = int'(in_data); m_cnt = 1; m_rptr = 0; m_busy = 1;
        if (in_eof) fin = 1; else m_fill = 1;
      end else if (m_fill && in_valid) begin
        if (m_cnt < MAXB) begin m_buf[m_cnt] = int'(in_data); m_cnt++; end
        if (in_eof) begin m_fill = 0; fin = 1; end
      end
      if (!acc && busy_clr) m_busy = 0;
      m_done = fin;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Compare to the model on every falling edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R3 model rx_count", int'(rx_count), m_cnt);
      check("R11 model busy", int'(busy), int'(m_busy));
      check("R4 model rx_done", int'(rx_done), int'(m_done));
      check("R2 model in_ready", int'(in_ready), int'(!m_busy && m_cnt < MAXB));
      check("R6 model rd_data", int'(rd_data), m_rd);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0; rd_strobe = 0; busy_clr = 0; dev_rst = 0;
    end
  endtask

  task automatic send_frame(input int len, input int base, input int stb_at);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = 8'(base + i); rd_strobe = (i == stb_at);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; rd_strobe = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); busy_clr = 1;
    @(negedge clk); busy_clr = 0;
  endtask

  task automatic read_one(input string tag, input int exp, input int exp_cnt);
    @(negedge clk); rd_strobe = 1;
    @(negedge clk); rd_strobe = 0;
    check(tag, int'(rd_data), exp);
    check(tag, int'(rx_count), exp_cnt);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 1);
    check("R1 rx_count", int'(rx_count), 0);
    check("R1 in_ready", int'(in_ready), 0);
    check("R1 rx_done", int'(rx_done), 0);
    check("R1 rd_data", int'(rd_data), 0);

    // R2 frame refused while busy
    send_frame(4, 8'h20, -1);
    check("R2 refused count", int'(rx_count), 0);
    check("R2 refused done", int'(rx_done), 0);

    // R11 clear lowers busy
    pulse_clr();
    check("R11 busy cleared", int'(busy), 0);
    check("R2 ready idle", int'(in_ready), 1);

    // R3 / R4 five-byte frame
    send_frame(5, 8'h10, -1);
    check("R4 done pulse", int'(rx_done), 1);
    check("R3 count", int'(rx_count), 5);
    check("R3 busy", int'(busy), 1);
    idle(1);
    check("R4 done falls", int'(rx_done), 0);

    // R6 in-order reads
    read_one("R6 byte0", 8'h10, 4);
    read_one("R6 byte1", 8'h11, 3);

    // R8 new frame rewinds pointer
    pulse_clr();
    send_frame(3, 8'h40, -1);
    read_one("R8 first byte of new frame", 8'h40, 2);
    read_one("R6 byte1 new", 8'h41, 1);
    read_one("R6 byte2 new", 8'h42, 0);

    // R7 empty read
    read_one("R7 empty read", 0, 0);

    // R4 single-beat frame
    pulse_clr();
    send_frame(1, 8'h77, -1);
    check("R4 single done", int'(rx_done), 1);
    check("R4 single count", int'(rx_count), 1);

    // R10 read during intake ignored
    pulse_clr();
    send_frame(6, 8'h30, 2);
    check("R10 count unchanged", int'(rx_count), 6);
    check("R10 rd_data zero", int'(rd_data), 0);

    // R9 device reset
    @(negedge clk); dev_rst = 1;
    @(negedge clk); dev_rst = 0;
    check("R9 count", int'(rx_count), 0);
    check("R9 busy", int'(busy), 1);
    check("R9 ready", int'(in_ready), 0);
    check("R9 rd_data", int'(rd_data), 0);

    // R5 oversize frame truncated
    pulse_clr();
    send_frame(1520, 0, -1);
    check("R5 count capped", int'(rx_count), MAXB);
    check("R5 done", int'(rx_done), 1);
    pulse_clr();
    check("R2 full store not ready", int'(in_ready), 0);
    send_frame(2, 8'h99, -1);
    check("R2 refused on full", int'(rx_count), MAXB);
    for (int i = 0; i < MAXB; i++) read_one("R5 stored byte", i & 8'hFF, MAXB - 1 - i);
    read_one("R7 empty after drain", 0, 0);

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule